// File: doc/BRIEF.md
# Host-bus register interface for an ADC acquisition card

This block is the bus-facing logic of a plug-in acquisition card. It watches an 8-bit host I/O bus and claims one window of eight consecutive addresses. The window's position is set by a bank of base switches. Inside the window, the low three address bits pick one register.

A write can start a conversion in one of two widths, or it can load the channel-select, amplifier-gain, counter and counter-mode registers. The card hands the conversion off to an external converter through a start/done handshake. It keeps a busy flag until the converter answers, and it holds the last result so the host can read it as two bytes. Each of the eight input channels has its own single-ended or differential switch. The setting for the channel currently selected shows up in the status byte.

Top module: `daq_bus_slave`

## Requirements
- R1: After reset, `bus_oe`, `conv_start`, `pga_gain`, `ctr_mode`, `conv_chan`, the busy flag, the counters and the stored result are all zero, and the decoded window base is 0x300.
- R2: An access is claimed only when `bus_addr[9:3]` equals the current base. A write outside the window changes no register. A read outside the window leaves `bus_oe` low.
- R3: `base_sw` holds address bits 9:3 of the window (0x60 means 0x300, 0x61 means 0x308, 0x62 means 0x310). It is registered, so a new setting takes effect one clock after the switches change. The first access after reset release still decodes against 0x300.
- R4: A claimed read strobe in cycle n makes `bus_oe` high with valid `bus_rdata` in cycle n+1 only.
- R5: A write to offset 0 (8-bit) or offset 1 (12-bit) while idle pulses `conv_start` for one cycle in the cycle after the write. It sets `conv_wide` to 0 or 1 respectively, and it sets the busy flag, which is bit 7 of the bytes read at offsets 2 and 3.
- R6: A start write while busy produces no `conv_start`, and the stored result is unchanged.
- R7: A `conv_done` pulse while busy clears busy and captures `conv_data`. In 8-bit mode, result bits 3:0 are stored as zero. A `conv_done` pulse while idle is ignored.
- R8: A read of offset 0 returns {result[3:0], 4'h0}. A read of offset 1 returns result[11:4].
- R9: A write to offset 2 stores `wdata[2:0]` as the channel, driven on `conv_chan`. A read of offset 2 returns {busy, 3'b0, mode_sw[channel], channel}, where 1 means differential.
- R10: A write to offset 3 stores `wdata[1:0]` as the gain on `pga_gain`. A read of offset 3 returns {busy, 5'b0, gain}.
- R11: Writes to offsets 4, 5 and 6 load counters 0, 1 and 2, and reads of those offsets return them. A write to offset 7 loads `ctr_mode`. A read of offset 7 is claimed and returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 10 | Host I/O address |
| bus_wdata | input | 8 | Host write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Read data, valid while bus_oe is high |
| bus_oe | output | 1 | Read data drive enable |
| base_sw | input | 7 | Base switches, address bits 9:3 |
| mode_sw | input | 8 | Per-channel differential select |
| conv_start | output | 1 | One-cycle conversion start |
| conv_wide | output | 1 | 1 for 12-bit conversion, 0 for 8-bit |
| conv_chan | output | 3 | Selected input channel |
| conv_done | input | 1 | Converter completion pulse |
| conv_data | input | 12 | Converter result, valid with conv_done |
| pga_gain | output | 2 | Amplifier gain code |
| ctr_mode | output | 8 | Counter mode word |

## Verification
Every register write takes effect at the clock edge that samples the strobe. That means `conv_start`, `conv_chan`, `pga_gain` and `ctr_mode` are checked half a cycle after that edge. Read data and `bus_oe` come out of one register stage, so the bench samples them at the falling edge after the sampling edge. The bench also looks one cycle later to confirm that the start pulse and the drive enable do not persist. The converter stub answers a fixed number of cycles after the start pulse. Busy and the result bytes are read only after the done pulse has been clocked in. A start issued while busy is judged by the absence of a pulse in the following cycle.

// File: rtl/daq_pkg.sv
package daq_pkg;

  localparam int OFS_W  = 3;
  localparam int RES_W  = 12;
  localparam int BYTE_W = 8;

  typedef enum logic [OFS_W-1:0] {
    OFS_RES_LO = 3'd0,
    OFS_RES_HI = 3'd1,
    OFS_STAT   = 3'd2,
    OFS_GAIN   = 3'd3,
    OFS_CTR0   = 3'd4,
    OFS_CTR1   = 3'd5,
    OFS_CTR2   = 3'd6,
    OFS_CMODE  = 3'd7
  } ofs_e;

  // low nibble of the result rides in the upper half of the first byte
  function automatic logic [BYTE_W-1:0] res_lo_byte(input logic [RES_W-1:0] r);
    return {r[3:0], 4'h0};
  endfunction

  function automatic logic [BYTE_W-1:0] res_hi_byte(input logic [RES_W-1:0] r);
    return r[11:4];
  endfunction

  function automatic logic [BYTE_W-1:0] stat_byte(input logic busy, input logic diff,
                                                  input logic [2:0] chan);
    return {busy, 3'b000, diff, chan};
  endfunction

  function automatic logic [BYTE_W-1:0] gain_byte(input logic busy, input logic [1:0] gain);
    return {busy, 5'b00000, gain};
  endfunction

  // narrow conversions drop the four least significant bits
  function automatic logic [RES_W-1:0] capture(input logic wide, input logic [RES_W-1:0] d);
    return wide ? d : {d[11:4], 4'h0};
  endfunction

endpackage

// File: rtl/daq_addr_decode.sv
module daq_addr_decode #(
  parameter int ADDR_W       = 10,
  parameter int DEFAULT_BASE = 'h300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-4:0] base_sw,
  input  logic              rd,
  input  logic              wr,
  output logic              rd_hit,
  output logic              wr_hit,
  output logic [2:0]        ofs
);
  localparam int BASE_W = ADDR_W - 3;
  localparam logic [BASE_W-1:0] BASE_RST = BASE_W'(DEFAULT_BASE >> 3);

  logic [BASE_W-1:0] base_q;
  logic              in_window;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) base_q <= BASE_RST;
    else        base_q <= base_sw;
  end

  assign in_window = (addr[ADDR_W-1:3] == base_q);
  assign rd_hit    = rd & in_window;
  assign wr_hit    = wr & in_window;
  assign ofs       = addr[2:0];

  // R3: the window base only moves to a value the switches presented one cycle earlier
  p_base_follows_sw_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(base_q) |-> (base_q == $past(base_sw)));

endmodule

// File: rtl/daq_conv_ctrl.sv
module daq_conv_ctrl
  import daq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             wide_req,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_data,
  output logic             busy,
  output logic             conv_start,
  output logic             conv_wide,
  output logic [RES_W-1:0] result
);
  logic start_evt;
  logic done_evt;

  assign start_evt = start_req & ~busy;
  assign done_evt  = conv_done & busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      conv_start <= 1'b0;
      conv_wide  <= 1'b0;
      result     <= '0;
    end else begin
      conv_start <= start_evt;
      if (start_evt) begin
        busy      <= 1'b1;
        conv_wide <= wide_req;
      end else if (done_evt) begin
        busy   <= 1'b0;
        result <= capture(conv_wide, conv_data);
      end
    end
  end

  p_start_sets_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (busy && conv_start));
  p_start_one_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  p_busy_start_dropped_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && busy) |=> !conv_start);
  p_result_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !done_evt |=> $stable(result));
  p_done_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !busy);

endmodule

// File: rtl/daq_regfile.sv
module daq_regfile #(
  parameter int NUM_CTR = 3,
  parameter int CH_W    = 3,
  parameter int GAIN_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [2:0]              ofs,
  input  logic [7:0]              wdata,
  output logic [CH_W-1:0]         chan,
  output logic [GAIN_W-1:0]       gain,
  output logic [7:0]              ctr_mode,
  output logic [NUM_CTR-1:0][7:0] ctr_vals
);
  import daq_pkg::*;

  logic wr_chan, wr_gain, wr_mode;

  assign wr_chan = wr_en && (ofs == OFS_STAT);
  assign wr_gain = wr_en && (ofs == OFS_GAIN);
  assign wr_mode = wr_en && (ofs == OFS_CMODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan     <= '0;
      gain     <= '0;
      ctr_mode <= '0;
    end else begin
      if (wr_chan) chan     <= wdata[CH_W-1:0];
      if (wr_gain) gain     <= wdata[GAIN_W-1:0];
      if (wr_mode) ctr_mode <= wdata;
    end
  end

  for (genvar gi = 0; gi < NUM_CTR; gi++) begin : g_ctr
    logic wr_this;
    assign wr_this = wr_en && (ofs == 3'(4 + gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctr_vals[gi] <= '0;
      else if (wr_this) ctr_vals[gi] <= wdata;
    end
  end

  p_gain_needs_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(gain) |-> $past(wr_gain));
  p_chan_needs_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(chan) |-> $past(wr_chan));

endmodule

// File: rtl/daq_bus_slave.sv
module daq_bus_slave #(
  parameter int ADDR_W       = 10,
  parameter int DEFAULT_BASE = 'h300,
  parameter int NUM_CH       = 8,
  parameter int NUM_CTR      = 3,
  parameter int GAIN_W       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  output logic              bus_oe,
  input  logic [ADDR_W-4:0] base_sw,
  input  logic [NUM_CH-1:0] mode_sw,
  output logic              conv_start,
  output logic              conv_wide,
  output logic [2:0]        conv_chan,
  input  logic              conv_done,
  input  logic [11:0]       conv_data,
  output logic [GAIN_W-1:0] pga_gain,
  output logic [7:0]        ctr_mode
);
  import daq_pkg::*;

  localparam int CH_W = $clog2(NUM_CH);
  localparam logic [1:0] CTR_LAST = 2'(NUM_CTR - 1);

  logic                    rd_hit, wr_hit;
  logic [2:0]              ofs;
  logic                    busy;
  logic [RES_W-1:0]        result;
  logic [NUM_CTR-1:0][7:0] ctr_vals;
  logic                    start_req;
  logic [7:0]              rd_mux;
  logic                    sel_diff;

  daq_addr_decode #(.ADDR_W(ADDR_W), .DEFAULT_BASE(DEFAULT_BASE)) u_dec (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .base_sw(base_sw),
    .rd(bus_rd), .wr(bus_wr), .rd_hit(rd_hit), .wr_hit(wr_hit), .ofs(ofs)
  );

  assign start_req = wr_hit && (ofs == OFS_RES_LO || ofs == OFS_RES_HI);

  daq_conv_ctrl u_conv (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .wide_req(ofs[0]),
    .conv_done(conv_done), .conv_data(conv_data), .busy(busy),
    .conv_start(conv_start), .conv_wide(conv_wide), .result(result)
  );

  daq_regfile #(.NUM_CTR(NUM_CTR), .CH_W(CH_W), .GAIN_W(GAIN_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_hit), .ofs(ofs), .wdata(bus_wdata),
    .chan(conv_chan), .gain(pga_gain), .ctr_mode(ctr_mode), .ctr_vals(ctr_vals)
  );

  assign sel_diff = mode_sw[conv_chan];

  always_comb begin
    rd_mux = 8'h00;
    case (ofs)
      OFS_RES_LO: rd_mux = res_lo_byte(result);
      OFS_RES_HI: rd_mux = res_hi_byte(result);
      OFS_STAT:   rd_mux = stat_byte(busy, sel_diff, conv_chan);
      OFS_GAIN:   rd_mux = gain_byte(busy, pga_gain);
      default: begin
        if (ofs[2] && ofs[1:0] <= CTR_LAST) rd_mux = ctr_vals[ofs[1:0]];
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_oe    <= 1'b0;
      bus_rdata <= 8'h00;
    end else begin
      bus_oe <= rd_hit;
      if (rd_hit) bus_rdata <= rd_mux;
    end
  end

  p_oe_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> $past(bus_rd));
  p_miss_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !rd_hit) |=> !bus_oe);

endmodule

// File: tb/sim_daq_bus_slave.sv
`timescale 1ns/1ps
module sim_daq_bus_slave;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic        bus_oe;
  logic [6:0]  base_sw = 7'h62;
  logic [7:0]  mode_sw = 8'hA5;
  logic        conv_start, conv_wide;
  logic [2:0]  conv_chan;
  logic        conv_done = 1'b0;
  logic [11:0] conv_data = '0;
  logic [1:0]  pga_gain;
  logic [7:0]  ctr_mode;

  int checks = 0, fails = 0;
  bit finished = 0;
  localparam int LAT = 4;

  always #2.5 clk = ~clk;

  daq_bus_slave u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [9:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, output logic [7:0] d, output logic oe);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata; oe = bus_oe;
  endtask

  task automatic finish_conv(input logic [11:0] d);
    repeat (LAT) @(negedge clk);
    conv_done = 1'b1; conv_data = d;
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic oe;
    logic [11:0] last_res;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 oe", bus_oe, 0);
    chk("R1 conv_start", conv_start, 0);
    chk("R1 gain", pga_gain, 0);
    chk("R1 ctr_mode", ctr_mode, 0);
    chk("R1 chan", conv_chan, 0);
    // R1/R3 first access decodes against 0x300 even with switches at 0x310
    rd(10'h302, d, oe);
    chk("R1 base 0x300 oe", oe, 1);
    chk("R1 status", d, {4'b0, mode_sw[0], 3'd0});
    rd(10'h302, d, oe);
    chk("R3 old base dropped", oe, 0);
    rd(10'h312, d, oe);
    chk("R3 new base oe", oe, 1);
    @(negedge clk);
    chk("R4 oe single cycle", bus_oe, 0);
    rd(10'h310, d, oe);
    chk("R1 result lo", d, 0);
    rd(10'h314, d, oe);
    chk("R1 counter", d, 0);

    // R2/R3 sweep of valid bases and neighbouring windows
    for (int b = 0; b < 3; b++) begin
      logic [9:0] base;
      base_sw = 7'(7'h60 + b);
      base = {base_sw, 3'b000};
      @(negedge clk);
      wr(base + 10'd4, 8'(8'h30 + b));
      wr(base - 10'd8 + 10'd4, 8'hEE);
      wr(base + 10'd8 + 10'd4, 8'hDD);
      rd(base + 10'd4, d, oe);
      chk("R2 miss write ignored", d, 8'h30 + b);
      chk("R3 hit oe", oe, 1);
      for (int o = 0; o < 8; o++) begin
        rd(base + 10'd8 + 10'(o), d, oe);
        chk("R2 miss read above", oe, 0);
        rd(base - 10'd8 + 10'(o), d, oe);
        chk("R2 miss read below", oe, 0);
      end
    end

    // R11 counters and counter mode
    for (int i = 0; i < 3; i++) begin
      for (int k = 0; k < 4; k++) begin
        logic [7:0] v;
        v = (k == 0) ? 8'h00 : (k == 1) ? 8'h5A : (k == 2) ? 8'hFF : 8'(i * 17 + 3);
        wr(10'h314 + 10'(i), v);
        rd(10'h314 + 10'(i), d, oe);
        chk("R11 counter readback", d, v);
      end
    end
    wr(10'h317, 8'h36);
    chk("R11 ctr_mode", ctr_mode, 8'h36);
    rd(10'h317, d, oe);
    chk("R11 offset7 oe", oe, 1);
    chk("R11 offset7 zero", d, 0);

    // R10 gain
    for (int g = 0; g < 4; g++) begin
      wr(10'h313, 8'(8'hFC | g));
      chk("R10 gain port", pga_gain, g);
      rd(10'h313, d, oe);
      chk("R10 gain read", d, g);
    end

    // R9 channel select and differential flag
    for (int c = 0; c < 8; c++) begin
      wr(10'h312, 8'(8'hF8 | c));
      chk("R9 chan port", conv_chan, c);
      rd(10'h312, d, oe);
      chk("R9 status", d, {4'b0, mode_sw[c], 3'(c)});
    end

    // R5..R8 conversions
    last_res = 12'h000;
    for (int t = 0; t < 6; t++) begin
      logic wide;
      logic [11:0] dat, exp_res;
      wide = (t % 2 == 0);
      dat = (t == 0) ? 12'hABC : (t == 1) ? 12'h5E7 : (t == 2) ? 12'hFFF :
            (t == 3) ? 12'hFFF : (t == 4) ? 12'h801 : 12'h3C5;
      wr(wide ? 10'h311 : 10'h310, 8'h00);
      chk("R5 start pulse", conv_start, 1);
      chk("R5 width", conv_wide, wide);
      @(negedge clk);
      chk("R5 pulse ends", conv_start, 0);
      rd(10'h312, d, oe);
      chk("R5 busy status", d[7], 1);
      rd(10'h313, d, oe);
      chk("R5 busy gain byte", d[7], 1);
      wr(10'h310, 8'h00);
      chk("R6 start while busy", conv_start, 0);
      rd(10'h310, d, oe);
      chk("R6 old lo", d, {last_res[3:0], 4'h0});
      rd(10'h311, d, oe);
      chk("R6 old hi", d, last_res[11:4]);
      finish_conv(dat);
      exp_res = wide ? dat : {dat[11:4], 4'h0};
      rd(10'h312, d, oe);
      chk("R7 busy cleared", d[7], 0);
      rd(10'h310, d, oe);
      chk("R8 lo byte", d, {exp_res[3:0], 4'h0});
      rd(10'h311, d, oe);
      chk("R8 hi byte", d, exp_res[11:4]);
      last_res = exp_res;
    end
    // R7 stray done while idle
    conv_done = 1'b1; conv_data = 12'h123;
    @(negedge clk);
    conv_done = 1'b0;
    rd(10'h311, d, oe);
    chk("R7 idle done ignored", d, last_res[11:4]);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule